// File: doc/BRIEF.md
# Phased Write-Port Dual-Copy Memory

This block is a small memory with one read port and one write port. It is built from two single-port RAM copies, each of which can either read or write in a given cycle, never both. A read may be issued every cycle. A write may only be issued every second cycle. In the cycle a write is accepted, the first copy stores it and the second copy serves the read. In the next cycle, the second copy stores the same word from a holding register and the first copy serves the read. After that pair of cycles the two copies hold the same contents.

A free-running phase bit is cleared by reset and toggles every cycle, so the first cycle after reset is phase 0. The parameter `WR_PHASE` chooses which phase accepts writes. The parameter `TRANSPARENT` chooses what a read returns when it names the address being written in the accepting cycle: the new word or the stored one. Two zero-latency debug outputs show the word held at one address in each copy. They exist so that verification can see both copies.

Top module: `phased_dual_mem`

## Requirements
- R1: During reset and in the first cycle after it, `rdData` is zero.
- R2: A read address presented on a clock edge yields its stored word on `rdData` after that edge, with one cycle of latency, and a read can be issued every cycle.
- R3: A write is accepted only on an edge whose phase equals `WR_PHASE`. Phase is 0 on the first edge after reset and alternates 0, 1, 0, 1 on later edges.
- R4: `wrEn` on an edge of the other phase is ignored, so the addressed word keeps its old value on later reads.
- R5: With `TRANSPARENT` = 0, a read of the address written on the same accepting edge returns the value stored before the write.
- R6: With `TRANSPARENT` = 1, a read of the address written on the same accepting edge returns the newly written word.
- R7: On every edge the read is served by the copy that is not writing on that edge, so a read never stalls or corrupts a write.
- R8: An accepted write reaches the second copy on the following edge, and after that edge `dbgDataA` and `dbgDataB` agree at every written address.
- R9: `dbgDataA` and `dbgDataB` follow `dbgAddr` with no clock delay.
- R10: A read issued on the edge after an accepted write returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request, honoured only in the write phase |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address, sampled every edge |
| rdData | output | DATA_W | Registered read data |
| dbgAddr | input | ADDR_W | Debug address for both copies |
| dbgDataA | output | DATA_W | Combinational word from the first copy |
| dbgDataB | output | DATA_W | Combinational word from the second copy |

## Verification
The assertions check on every cycle that writes are accepted only in the allowed phase, that writes in the other phase are dropped, that every accepted write is committed to the second copy on the next edge, that the read is steered away from the copy being written, and that a transparent collision returns the new word. Some behaviour only the bench's scenarios can show. This covers the returned values under collision in both modes, the agreement of the two copies through the debug outputs after a completed pair, and the data a one-cycle-latency read returns. The bench shows these with two instances that use opposite phases and modes.

// File: rtl/phmem_pkg.sv
package phmem_pkg;
  typedef struct packed {
    logic acceptWr;  // first copy stores the incoming word
    logic commitB;   // second copy stores the held word
    logic readB;     // second copy serves this edge's read
  } memStrobes_t;
endpackage

// File: rtl/ram_1rw.sv
module ram_1rw #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  // single port: a write edge performs no read
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (!we) q <= cells[addr];
  end

  assign dbgData = cells[dbgAddr];
endmodule

// File: rtl/phmem_ctrl.sv
module phmem_ctrl
  import phmem_pkg::*;
#(
  parameter int WR_PHASE = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  output memStrobes_t strb
);
  logic phase;
  logic pending;
  logic inWrPhase;

  assign inWrPhase = (phase == WR_PHASE[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      pending <= 1'b0;
    end else begin
      phase   <= ~phase;
      pending <= wrEn & inWrPhase;
    end
  end

  always_comb begin
    strb.acceptWr = wrEn & inWrPhase;
    strb.commitB  = pending;
    strb.readB    = inWrPhase;
  end
endmodule

// File: rtl/phmem_dp.sv
module phmem_dp
  import phmem_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter bit TRANSPARENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  memStrobes_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgDataA,
  output logic [DATA_W-1:0] dbgDataB
);
  localparam int COPIES = 2;

  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;
  logic              selB;
  logic              bypassQ;
  logic [DATA_W-1:0] copyQ   [COPIES];
  logic [DATA_W-1:0] copyDbg [COPIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      holdAddr <= '0;
      holdData <= '0;
      selB     <= 1'b0;
      bypassQ  <= 1'b0;
    end else begin
      if (strb.acceptWr) begin
        holdAddr <= wrAddr;
        holdData <= wrData;
      end
      selB    <= strb.readB;
      bypassQ <= TRANSPARENT && strb.acceptWr && (rdAddr == wrAddr);
    end
  end

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic              copyWe;
    logic [ADDR_W-1:0] copyAddr;
    logic [DATA_W-1:0] copyWd;

    if (c == 0) begin : g_first
      assign copyWe   = strb.acceptWr;
      assign copyAddr = strb.acceptWr ? wrAddr : rdAddr;
      assign copyWd   = wrData;
    end else begin : g_second
      assign copyWe   = strb.commitB;
      assign copyAddr = strb.commitB ? holdAddr : rdAddr;
      assign copyWd   = holdData;
    end

    ram_1rw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk(clk), .rst(rst), .we(copyWe), .addr(copyAddr), .wdata(copyWd),
      .q(copyQ[c]), .dbgAddr(dbgAddr), .dbgData(copyDbg[c])
    );
  end

  assign rdData   = bypassQ ? holdData : (selB ? copyQ[1] : copyQ[0]);
  assign dbgDataA = copyDbg[0];
  assign dbgDataB = copyDbg[1];
endmodule

// File: rtl/phased_dual_mem.sv
module phased_dual_mem
  import phmem_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int WR_PHASE    = 0,
  parameter bit TRANSPARENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgDataA,
  output logic [DATA_W-1:0] dbgDataB
);
  memStrobes_t strb;

  phmem_ctrl #(.WR_PHASE(WR_PHASE)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .strb(strb)
  );

  phmem_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRANSPARENT(TRANSPARENT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .dbgAddr(dbgAddr),
    .dbgDataA(dbgDataA), .dbgDataB(dbgDataB)
  );
endmodule

// File: rtl/phased_dual_mem_chk.sv
module phased_dual_mem_chk
  import phmem_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int WR_PHASE    = 0,
  parameter bit TRANSPARENT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input memStrobes_t       strb
);
  logic chkPhase;

  always_ff @(posedge clk) begin
    if (rst) chkPhase <= 1'b0;
    else     chkPhase <= ~chkPhase;
  end

  p_accept_phase_r3: assert property (@(posedge clk) disable iff (rst)
    strb.acceptWr |-> (chkPhase == WR_PHASE[0]));

  p_ignore_off_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && chkPhase != WR_PHASE[0]) |-> !strb.acceptWr);

  p_read_steer_r7: assert property (@(posedge clk) disable iff (rst)
    strb.commitB |-> !strb.readB);

  p_commit_next_r8: assert property (@(posedge clk) disable iff (rst)
    strb.acceptWr |=> strb.commitB);

  p_bypass_new_r6: assert property (@(posedge clk) disable iff (rst)
    (TRANSPARENT && strb.acceptWr && rdAddr == wrAddr) |=> (rdData == $past(wrData)));
endmodule

bind phased_dual_mem phased_dual_mem_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_PHASE(WR_PHASE), .TRANSPARENT(TRANSPARENT)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .strb(strb)
);

// File: tb/sim_phased_dual_mem.sv
`timescale 1ns/1ps
module sim_phased_dual_mem;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0, dbgAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rd [2];
  logic [DW-1:0] dA [2];
  logic [DW-1:0] dB [2];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // u0: writes on even phase, transparent
  phased_dual_mem #(.ADDR_W(AW), .DATA_W(DW), .WR_PHASE(0), .TRANSPARENT(1'b1)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rd[0]), .dbgAddr(dbgAddr),
    .dbgDataA(dA[0]), .dbgDataB(dB[0])
  );
  // u1: writes on odd phase, non-transparent
  phased_dual_mem #(.ADDR_W(AW), .DATA_W(DW), .WR_PHASE(1), .TRANSPARENT(1'b0)) u1 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rd[1]), .dbgAddr(dbgAddr),
    .dbgDataA(dA[1]), .dbgDataB(dB[1])
  );

  // reference model built from the requirements
  logic [DW-1:0] mdl [2][DEPTH];
  bit            known [2][DEPTH];
  bit            ph [2];
  logic [DW-1:0] expRd [2];
  bit            expOk [2];
  bit            lastAcc [2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      bit acc;
      if (rst) begin
        ph[i] = 1'b0; expRd[i] = '0; expOk[i] = 1'b1; lastAcc[i] = 1'b0;
        for (int a = 0; a < DEPTH; a++) known[i][a] = 1'b0;
      end else begin
        acc = wrEn && (ph[i] == i[0]);
        if (i == 0 && acc && rdAddr == wrAddr) begin
          expRd[i] = wrData; expOk[i] = 1'b1;
        end else begin
          expRd[i] = mdl[i][rdAddr]; expOk[i] = known[i][rdAddr];
        end
        if (acc) begin
          mdl[i][wrAddr] = wrData; known[i][wrAddr] = 1'b1;
        end
        lastAcc[i] = acc;
        ph[i] = ~ph[i];
      end
    end
  end

  task automatic check(input string tag, input int inst, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s u%0d actual=%02h expected=%02h", tag, inst, act, exp);
    end
  endtask

  task automatic stepCheck(input string tag);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++)
      if (expOk[i]) check(tag, i, rd[i], expRd[i]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) check("R1 during reset", i, rd[i], '0);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) check("R1 after reset", i, rd[i], '0);
  endtask

  // each write held two cycles so both instances accept it; R3, R7 read stream
  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      wrEn = 1'b1; wrAddr = a[AW-1:0]; wrData = 8'h30 + 8'(a * 7);
      rdAddr = a[AW-1:0] - 1'b1;
      stepCheck("R3 R7 fill");
      stepCheck("R3 R7 fill");
    end
    wrEn = 1'b0;
  endtask

  task automatic t_readback();
    for (int a = 0; a < DEPTH; a++) begin
      rdAddr = AW'(DEPTH - 1 - a);
      stepCheck("R2 readback");
    end
  endtask

  task automatic t_collide();
    while (ph[0] != 1'b0) @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd5; rdAddr = 4'd5; wrData = 8'h5A;
    stepCheck("R6 transparent collision");   // u0 accepts, u1 ignores
    wrData = 8'hA5;
    stepCheck("R5 old value collision");     // u1 accepts, u0 ignores (R4)
    wrEn = 1'b0;
    stepCheck("R10 read after write");
    stepCheck("R10 read after write");
  endtask

  task automatic t_ignore();
    while (ph[0] != 1'b1) @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd3; wrData = 8'hEE; rdAddr = 4'd9;
    stepCheck("R4 off phase write");          // u0 ignores, u1 accepts
    wrEn = 1'b0; rdAddr = 4'd3;
    stepCheck("R4 ignored word");
    stepCheck("R4 ignored word");
  endtask

  task automatic t_stream();
    for (int k = 0; k < 24; k++) begin
      wrEn = k[0]; wrAddr = AW'(k * 3); wrData = 8'(8'h90 ^ k);
      rdAddr = AW'(k * 5 + 1);
      stepCheck("R7 streaming");
    end
    wrEn = 1'b0;
  endtask

  task automatic t_debug();
    repeat (3) @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      dbgAddr = a[AW-1:0];
      #1;
      for (int i = 0; i < 2; i++) begin
        if (known[i][a]) begin
          check("R9 debug A", i, dA[i], mdl[i][a]);
          check("R8 copies agree", i, dB[i], dA[i]);
        end
      end
    end
  endtask

  initial begin
    t_reset();
    t_fill();
    t_readback();
    t_collide();
    t_ignore();
    t_stream();
    t_debug();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule